// File: doc/BRIEF.md
# Bus master handover sequencer

This block sits beside one bus master on a shared, arbitrated bus. It decides when that master may drive the bus. The arbiter grants the master in a given bus cycle. The previous owner's transfer may still be stalled by the bus wait signal. The sequencer tracks both and produces the master's transfer-type code, the bus lock signal and two drive enables: one for the transfer-type lines and one for the address and control lines.

While a grant is pending and the previous transfer is still waited, the master drives only an address-only code and keeps its address lines off the bus. Ownership passes at the end of a bus cycle in which the grant is high and the wait signal is low. The first owned cycle is always an address-only turnaround cycle. Real transfers may start in the cycle after it: non-sequential first, then sequential for back-to-back transfers. A request made with the lock request high marks the transfer as locked.

A master that loses its grant while it owns the bus finishes its current cycle and then releases the bus. A parameter makes the instance the system's default master. A default master owns the bus from reset, and when it has nothing to do it fills the bus with address-only cycles and lock low.

Top module: `bus_handover_seq`

## Requirements
- R1: During reset a normal instance drives nothing: transfer-type enable 0, address enable 0, type 00, lock 0. A default-master instance owns the bus in reset: both enables 1, type 00, lock 0.
- R2: While the grant is high and the block does not own the bus, in the same cycle it drives transfer-type enable 1 with type 00 (address-only) and address enable 0, for as many cycles as the wait lasts.
- R3: Ownership is taken only at a clock edge where grant is 1 and wait is 0. Address enable rises in the cycle after that edge.
- R4: The first owned cycle carries type 00 even if a transfer is requested. A requested transfer appears in the following cycle.
- R5: If the grant is withdrawn before wait goes low, the pending handover is dropped and address enable never rises.
- R6: Type encoding is 00 address-only, 10 non-sequential, 11 sequential, and 01 is never driven. A transfer that follows an address-only cycle is 10. A transfer that follows a completed transfer is 11. With no request, the owner drives 00.
- R7: While wait is 1, the type, lock and address enable hold their values at the next edge.
- R8: Lock is 1 in each transfer cycle whose request was made with lock request 1. It stays 1 until that sequence's last transfer completes with wait 0, and it is 0 in the following cycle once the lock request has dropped. Lock is 0 in every address-only cycle.
- R9: If an owner loses its grant, it keeps both enables high until an edge with wait 0. After that edge, address enable and transfer-type enable are 0.
- R10: A default-master instance that owns the bus with no request drives type 00 and lock 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| grant_i | input | 1 | Arbiter grant for this master |
| wait_i | input | 1 | Bus wait: 1 while the current transfer is stalled |
| xfer_req_i | input | 1 | Master wants to issue a transfer in the next cycle |
| lock_req_i | input | 1 | Requested transfer belongs to a locked sequence |
| ttype_o | output | 2 | Transfer type: 00 address-only, 10 non-sequential, 11 sequential |
| tran_en_o | output | 1 | Drive enable for the transfer-type lines |
| addr_en_o | output | 1 | Drive enable for address and control lines |
| lock_o | output | 1 | Bus lock |

## Verification
The pending-grant response (transfer-type enable with address-only) follows grant in the same cycle, with no register in the path. Ownership, type and lock are registered, so each changes one edge after the inputs that cause it, and any wait-high cycle delays them by one more edge. Every expected result is pushed for the cycle in which it is due, and it is compared 2 ns after the falling edge, with the inputs of that cycle already applied and the next rising edge still ahead. The sequences cover a withdrawn pending grant, a waited handover, a turnaround with a request already present, a locked burst stretched by wait, a grant lost while owning, and the default-master reset and idle states.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int TT_W = 2;

    typedef enum logic [TT_W-1:0] {
        TT_IDLE   = 2'b00,
        TT_RSVD   = 2'b01,
        TT_NONSEQ = 2'b10,
        TT_SEQ    = 2'b11
    } ttype_e;

    typedef struct packed {
        ttype_e kind;
        logic   lock;
    } cyc_t;

    localparam cyc_t CYC_IDLE = '{kind: TT_IDLE, lock: 1'b0};

    function automatic ttype_e pick_type(input logic req, input ttype_e prev);
        if (!req)
            return TT_IDLE;
        else if (prev == TT_NONSEQ || prev == TT_SEQ)
            return TT_SEQ;
        else
            return TT_NONSEQ;
    endfunction

endpackage

// File: rtl/hs_owner_track.sv
module hs_owner_track #(
    parameter bit RESET_OWNED = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic grant_i,
    input  logic busy_i,
    output logic owned_o,
    output logic acquire_o
);

    logic owned_q;

    // bus cycle boundary: only then may ownership change hands
    always_ff @(posedge clk) begin
        if (rst)
            owned_q <= RESET_OWNED;
        else if (!busy_i)
            owned_q <= grant_i;
    end

    assign owned_o   = owned_q;
    assign acquire_o = grant_i & ~busy_i & ~owned_q;

endmodule

// File: rtl/hs_cycle_gen.sv
module hs_cycle_gen
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic grant_i,
    input  logic busy_i,
    input  logic owned_i,
    input  logic acquire_i,
    input  logic req_i,
    input  logic lock_req_i,
    output cyc_t cyc_o
);

    cyc_t cyc_q;
    cyc_t cyc_n;

    always_comb begin
        cyc_n = cyc_q;
        if (!busy_i) begin
            if (acquire_i || !grant_i || !owned_i) begin
                // turnaround after a takeover, or no ownership next cycle
                cyc_n = CYC_IDLE;
            end else begin
                cyc_n.kind = pick_type(req_i, cyc_q.kind);
                cyc_n.lock = req_i & lock_req_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cyc_q <= CYC_IDLE;
        else
            cyc_q <= cyc_n;
    end

    assign cyc_o = cyc_q;

endmodule

// File: rtl/hs_drive_ctl.sv
module hs_drive_ctl
    import hs_pkg::*;
(
    input  logic            owned_i,
    input  logic            grant_i,
    input  cyc_t            cyc_i,
    output logic [TT_W-1:0] ttype_o,
    output logic            tran_en_o,
    output logic            addr_en_o,
    output logic            lock_o
);

    always_comb begin
        addr_en_o = owned_i;
        tran_en_o = owned_i | grant_i;
        ttype_o   = owned_i ? cyc_i.kind : TT_IDLE;
        lock_o    = owned_i & cyc_i.lock;
    end

endmodule

// File: rtl/bus_handover_seq.sv
module bus_handover_seq
    import hs_pkg::*;
#(
    parameter bit DEFAULT_MASTER = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            grant_i,
    input  logic            wait_i,
    input  logic            xfer_req_i,
    input  logic            lock_req_i,
    output logic [TT_W-1:0] ttype_o,
    output logic            tran_en_o,
    output logic            addr_en_o,
    output logic            lock_o
);

    logic owned;
    logic acquire;
    cyc_t cyc;

    hs_owner_track #(.RESET_OWNED(DEFAULT_MASTER)) u_owner (
        .clk       (clk),
        .rst       (rst),
        .grant_i   (grant_i),
        .busy_i    (wait_i),
        .owned_o   (owned),
        .acquire_o (acquire)
    );

    hs_cycle_gen u_cycle (
        .clk        (clk),
        .rst        (rst),
        .grant_i    (grant_i),
        .busy_i     (wait_i),
        .owned_i    (owned),
        .acquire_i  (acquire),
        .req_i      (xfer_req_i),
        .lock_req_i (lock_req_i),
        .cyc_o      (cyc)
    );

    hs_drive_ctl u_drive (
        .owned_i   (owned),
        .grant_i   (grant_i),
        .cyc_i     (cyc),
        .ttype_o   (ttype_o),
        .tran_en_o (tran_en_o),
        .addr_en_o (addr_en_o),
        .lock_o    (lock_o)
    );

endmodule

// File: rtl/bus_handover_seq_chk.sv
module bus_handover_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       grant_i,
    input logic       wait_i,
    input logic [1:0] ttype_o,
    input logic       tran_en_o,
    input logic       addr_en_o,
    input logic       lock_o
);

    AST_NO_RSVD_TYPE: assert property (@(posedge clk) disable iff (rst)
        tran_en_o |-> ttype_o != 2'b01) else $error("reserved type driven"); // R6

    AST_TAKE_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_en_o) |-> $past(grant_i) && !$past(wait_i)) else $error("ownership without grant"); // R3

    AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_en_o) |-> ttype_o == 2'b00) else $error("no turnaround cycle"); // R4

    AST_PENDING_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!addr_en_o && wait_i) |=> !addr_en_o) else $error("address driven during wait"); // R5

    AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (rst)
        wait_i |=> $stable(ttype_o) && $stable(lock_o) && $stable(addr_en_o)) else $error("change during wait"); // R7

    AST_LOCK_ON_XFER: assert property (@(posedge clk) disable iff (rst)
        lock_o |-> ttype_o[1]) else $error("lock in address-only cycle"); // R8

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (addr_en_o && !grant_i && !wait_i) |=> !addr_en_o && !tran_en_o) else $error("bus not released"); // R9

endmodule

bind bus_handover_seq bus_handover_seq_chk u_chk (.*);

// File: tb/bus_handover_seq_test.sv
`timescale 1ns/1ps
module bus_handover_seq_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic g = 0, w = 0, r = 0, l = 0;
    logic dg = 1, dw = 0, dr = 0, dl = 0;

    logic [1:0] tt,  dtt;
    logic ten, aen, lk, dten, daen, dlk;

    always #4 clk = ~clk;   // 125 MHz

    bus_handover_seq #(.DEFAULT_MASTER(1'b0)) uut (
        .clk(clk), .rst(rst), .grant_i(g), .wait_i(w),
        .xfer_req_i(r), .lock_req_i(l),
        .ttype_o(tt), .tran_en_o(ten), .addr_en_o(aen), .lock_o(lk)
    );

    bus_handover_seq #(.DEFAULT_MASTER(1'b1)) uut_dflt (
        .clk(clk), .rst(rst), .grant_i(dg), .wait_i(dw),
        .xfer_req_i(dr), .lock_req_i(dl),
        .ttype_o(dtt), .tran_en_o(dten), .addr_en_o(daen), .lock_o(dlk)
    );

    typedef struct {
        bit         sel;
        logic [1:0] tt;
        logic       ten;
        logic       aen;
        logic       lk;
        string      tag;
    } exp_t;

    exp_t q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // driver: apply one cycle of inputs and queue what is due in that cycle
    task automatic step(input bit sel, input logic gi, wi, ri, li,
                        input logic [1:0] et, input logic eten, eaen, elk,
                        input string tag);
        exp_t e;
        @(negedge clk);
        if (sel) begin dg = gi; dw = wi; dr = ri; dl = li; end
        else     begin g = gi;  w = wi;  r = ri;  l = li;  end
        e.sel = sel; e.tt = et; e.ten = eten; e.aen = eaen; e.lk = elk; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare in the low phase, after the inputs have settled
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                logic [1:0] at;
                logic aten, aaen, alk;
                e = q.pop_front();
                at   = e.sel ? dtt  : tt;
                aten = e.sel ? dten : ten;
                aaen = e.sel ? daen : aen;
                alk  = e.sel ? dlk  : lk;
                n_vec++;
                if (at !== e.tt || aten !== e.ten || aaen !== e.aen || alk !== e.lk) begin
                    n_bad++;
                    $display("FAIL %s: got tt=%b ten=%b aen=%b lk=%b expected tt=%b ten=%b aen=%b lk=%b",
                             e.tag, at, aten, aaen, alk, e.tt, e.ten, e.aen, e.lk);
                end
            end
        end
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // reset state of both variants
        step(0, 0,0,0,0, 2'b00, 0,0,0, "R1 normal reset");
        step(1, 1,0,0,0, 2'b00, 1,1,0, "R1 R10 default reset");
        @(negedge clk);
        rst = 1'b0;
        // normal instance
        step(0, 0,0,1,0, 2'b00, 0,0,0, "R1 idle without grant");
        step(0, 1,1,0,0, 2'b00, 1,0,0, "R2 pending during wait");
        step(0, 1,1,0,0, 2'b00, 1,0,0, "R2 pending second wait cycle");
        step(0, 0,1,0,0, 2'b00, 0,0,0, "R5 grant withdrawn");
        step(0, 0,0,0,0, 2'b00, 0,0,0, "R5 wait ends without grant");
        step(0, 0,0,1,0, 2'b00, 0,0,0, "R5 never drove address");
        step(0, 1,1,1,0, 2'b00, 1,0,0, "R2 pending again");
        step(0, 1,0,1,0, 2'b00, 1,0,0, "R3 grant with wait low, not yet owner");
        step(0, 1,0,1,0, 2'b00, 1,1,0, "R3 R4 owner turnaround");
        step(0, 1,0,1,0, 2'b10, 1,1,0, "R6 first transfer non-sequential");
        step(0, 1,1,0,0, 2'b11, 1,1,0, "R6 second transfer sequential");
        step(0, 1,1,0,0, 2'b11, 1,1,0, "R7 held during wait");
        step(0, 1,0,0,0, 2'b11, 1,1,0, "R7 held until wait low");
        step(0, 1,0,1,1, 2'b00, 1,1,0, "R6 owner idle address-only");
        step(0, 1,0,1,1, 2'b10, 1,1,1, "R8 locked first transfer");
        step(0, 1,1,1,0, 2'b11, 1,1,1, "R8 locked transfer waited");
        step(0, 1,0,1,0, 2'b11, 1,1,1, "R8 lock held to completion");
        step(0, 1,0,0,0, 2'b11, 1,1,0, "R8 lock dropped");
        step(0, 0,1,1,0, 2'b00, 1,1,0, "R9 grant lost during wait");
        step(0, 0,0,1,0, 2'b00, 1,1,0, "R9 still driving until wait low");
        step(0, 0,0,0,0, 2'b00, 0,0,0, "R9 released");
        // default-master instance
        step(1, 1,0,0,0, 2'b00, 1,1,0, "R10 default idle owner");
        step(1, 1,0,1,1, 2'b00, 1,1,0, "R10 request not yet visible");
        step(1, 1,0,0,0, 2'b10, 1,1,1, "R10 default locked transfer");
        step(1, 1,0,0,0, 2'b00, 1,1,0, "R10 back to address-only, lock low");
        @(negedge clk);
        @(negedge clk);
        #3;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule